// File: doc/BRIEF.md
# Serial-In Parallel Column Driver Logic

This block is the digital control core of a column driver for display or print-head arrays. A serial bit stream is loaded into a chain of stages, one bit per falling edge of an external shift clock, and each stage drives one channel output. The channel outputs are plain logic "channel on" bits that feed the output stages. The last stage is also brought out as a cascade output, so several devices can be chained into a wider column.

Two control inputs select what the channels show. Strobe (active low) turns every channel on and takes priority over everything else. With strobe high, the enable input (active high) either blanks all channels or lets each channel show the bit held in its stage. Shifting runs on regardless of either control.

All inputs are asynchronous to a fast system clock. They are brought in through two-flop synchronizers, and the shift clock's falling edge is found with an edge detector. A parameter mirrors the order in which stages map onto channels.

Top module: `colDriveCore`

## Requirements
- R1: The chain holds NUM_STAGES stages (default 32), numbered 1 to NUM_STAGES. A synchronous active-high reset clears every stage. After reset, with strobe high and enable low, all channels and the cascade output read 0.
- R2: Each falling edge of the shift clock moves the chain exactly one place. Stage 1 takes the serial input, and stage n takes the old value of stage n-1. Rising edges and steady levels move nothing.
- R3: The cascade output always equals the last stage. After NUM_STAGES shifts it shows the first bit shifted in, and after NUM_STAGES+1 shifts it shows the second bit.
- R4: Strobe and enable have no effect on shifting. Bits shifted while either control is asserted appear in the chain once normal display resumes.
- R5: While strobe is low, every channel output is 1, whatever the enable level and the chain contents.
- R6: While strobe is high and enable is low, every channel output is 0.
- R7: While strobe and enable are both high, each channel output equals the bit of the stage that feeds it.
- R8: With REVERSE = 0, channel bit k-1 (channel k) is fed from stage k.
- R9: With REVERSE = 1, channel bit k-1 (channel k) is fed from stage NUM_STAGES+1-k.
- R10: A change on strobe or enable reaches the channel outputs after two system-clock edges. A shift-clock falling edge reaches the stages and the cascade output within three system-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shiftClkIn | input | 1 | Asynchronous shift clock; the chain moves on its falling edge |
| serialIn | input | 1 | Serial data input for stage 1 |
| strobeN | input | 1 | Active-low force-all-on control |
| enableIn | input | 1 | Active-high display enable |
| cascadeOut | output | 1 | Copy of the last stage, for the next device |
| chanOn | output | NUM_STAGES | Channel on bits, bit k-1 is channel k |

## Verification
A corrupted or skipped stage shows up on chanOn as soon as display is enabled, at the channel that the ordering maps it to. Because of the mirrored mapping, the same fault appears at opposite channels in the two variants. A missed or doubled shift puts every later bit one place off, so the whole channel pattern and the cascade output go wrong on the next shift. A fault in the mode selection shows on all channels two clock edges after a control changes.

// File: rtl/colDrivePkg.sv
package colDrivePkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic shiftStep;  // one-cycle pulse per shift-clock falling edge
    logic shiftBit;   // serial bit aligned with shiftStep
    logic forceOn;    // all channels on
    logic forceOff;   // all channels off (only when forceOn is low)
  } ctrlStrobes_t;
endpackage

// File: rtl/colSyncCtrl.sv
module colSyncCtrl
  import colDrivePkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shiftClkIn,
  input  logic         serialIn,
  input  logic         strobeN,
  input  logic         enableIn,
  output ctrlStrobes_t ctrl
);
  localparam int LAST = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH:0]  clkSync;   // one extra flop for edge detection
  logic [LAST:0]        dataSync;
  logic [LAST:0]        strobeSync;
  logic [LAST:0]        enableSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkSync    <= '0;
      dataSync   <= '0;
      strobeSync <= '1;
      enableSync <= '0;
    end else begin
      clkSync    <= {clkSync[SYNC_DEPTH-1:0], shiftClkIn};
      dataSync   <= {dataSync[LAST-1:0], serialIn};
      strobeSync <= {strobeSync[LAST-1:0], strobeN};
      enableSync <= {enableSync[LAST-1:0], enableIn};
    end
  end

  always_comb begin
    ctrl.shiftStep = clkSync[SYNC_DEPTH] & ~clkSync[LAST];
    ctrl.shiftBit  = dataSync[LAST];
    ctrl.forceOn   = ~strobeSync[LAST];
    ctrl.forceOff  = strobeSync[LAST] & ~enableSync[LAST];
  end
endmodule

// File: rtl/colShiftPath.sv
module colShiftPath
  import colDrivePkg::*;
#(
  parameter int NUM_STAGES = 32,
  parameter bit REVERSE    = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          ctrl,
  output logic [NUM_STAGES-1:0] stageVec,
  output logic                  cascadeOut,
  output logic [NUM_STAGES-1:0] chanOn
);
  localparam int TOP = NUM_STAGES - 1;

  logic [TOP:0] mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageVec <= '0;
    end else if (ctrl.shiftStep) begin
      stageVec <= {stageVec[TOP-1:0], ctrl.shiftBit};
    end
  end

  assign cascadeOut = stageVec[TOP];

  for (genvar k = 0; k < NUM_STAGES; k++) begin : gMap
    if (REVERSE) begin : gRev
      assign mapped[k] = stageVec[TOP-k];
    end else begin : gFwd
      assign mapped[k] = stageVec[k];
    end
  end

  always_comb begin
    if (ctrl.forceOn)       chanOn = '1;
    else if (ctrl.forceOff) chanOn = '0;
    else                    chanOn = mapped;
  end
endmodule

// File: rtl/colDriveCore.sv
module colDriveCore
  import colDrivePkg::*;
#(
  parameter int NUM_STAGES = 32,
  parameter bit REVERSE    = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shiftClkIn,
  input  logic                  serialIn,
  input  logic                  strobeN,
  input  logic                  enableIn,
  output logic                  cascadeOut,
  output logic [NUM_STAGES-1:0] chanOn
);
  ctrlStrobes_t          ctrlBus;
  logic [NUM_STAGES-1:0] stageVec;

  colSyncCtrl #(.SYNC_DEPTH(2)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .shiftClkIn(shiftClkIn),
    .serialIn  (serialIn),
    .strobeN   (strobeN),
    .enableIn  (enableIn),
    .ctrl      (ctrlBus)
  );

  colShiftPath #(.NUM_STAGES(NUM_STAGES), .REVERSE(REVERSE)) uPath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrlBus),
    .stageVec  (stageVec),
    .cascadeOut(cascadeOut),
    .chanOn    (chanOn)
  );
endmodule

// File: rtl/colDriveChecker.sv
module colDriveChecker #(
  parameter int NUM_STAGES = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  shiftStep,
  input logic                  shiftBit,
  input logic                  forceOn,
  input logic                  forceOff,
  input logic [NUM_STAGES-1:0] stageVec,
  input logic                  cascadeOut,
  input logic [NUM_STAGES-1:0] chanOn
);
  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    shiftStep |=> stageVec == {$past(stageVec[NUM_STAGES-2:0]), $past(shiftBit)});
  // R4
  hold_stages_chk: assert property (@(posedge clk) disable iff (rst)
    !shiftStep |=> $stable(stageVec));
  // R3
  cascade_follow_chk: assert property (@(posedge clk) disable iff (rst)
    shiftStep |=> cascadeOut == $past(stageVec[NUM_STAGES-2]));
  // R5
  all_on_chk: assert property (@(posedge clk) disable iff (rst)
    forceOn |-> &chanOn);
  // R6
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    forceOff |-> chanOn == '0);
  // R7
  follow_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!forceOn && !forceOff) |-> $countones(chanOn) == $countones(stageVec));
endmodule

bind colDriveCore colDriveChecker #(.NUM_STAGES(NUM_STAGES)) uChk (
  .clk       (clk),
  .rst       (rst),
  .shiftStep (ctrlBus.shiftStep),
  .shiftBit  (ctrlBus.shiftBit),
  .forceOn   (ctrlBus.forceOn),
  .forceOff  (ctrlBus.forceOff),
  .stageVec  (stageVec),
  .cascadeOut(cascadeOut),
  .chanOn    (chanOn)
);

// File: tb/tb_colDriveCore.sv
`timescale 1ns/1ps
module tb_colDriveCore;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst, shiftClkIn, serialIn, strobeN, enableIn;
  logic cascFwd, cascRev;
  logic [W-1:0] chanFwd, chanRev;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 1'b0;
  bit model[W];   // model[0] is stage 1
  bit history[$];

  always #2.5 clk = ~clk;

  colDriveCore #(.NUM_STAGES(W), .REVERSE(1'b0)) dut (
    .clk(clk), .rst(rst), .shiftClkIn(shiftClkIn), .serialIn(serialIn),
    .strobeN(strobeN), .enableIn(enableIn), .cascadeOut(cascFwd), .chanOn(chanFwd));

  colDriveCore #(.NUM_STAGES(W), .REVERSE(1'b1)) dutRev (
    .clk(clk), .rst(rst), .shiftClkIn(shiftClkIn), .serialIn(serialIn),
    .strobeN(strobeN), .enableIn(enableIn), .cascadeOut(cascRev), .chanOn(chanRev));

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog: actual run still going, expected finished");
      finishRun();
    end
  end

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // Reference channel value from the requirements
  function automatic logic [W-1:0] expChan(bit rev);
    logic [W-1:0] v;
    for (int k = 1; k <= W; k++) begin
      if (!strobeN)       v[k-1] = 1'b1;                        // R5
      else if (!enableIn) v[k-1] = 1'b0;                        // R6
      else if (!rev)      v[k-1] = model[k-1];                  // R7 R8
      else                v[k-1] = model[W-k];                  // R7 R9
    end
    return v;
  endfunction

  task automatic compare(string tag);
    @(negedge clk);
    vectors++;
    if (chanFwd !== expChan(1'b0) || cascFwd !== model[W-1]) begin
      misses++;
      $display("FAIL %s fwd: actual chan=%h casc=%b expected chan=%h casc=%b",
               tag, chanFwd, cascFwd, expChan(1'b0), model[W-1]);
    end
    vectors++;
    if (chanRev !== expChan(1'b1) || cascRev !== model[W-1]) begin
      misses++;
      $display("FAIL %s rev: actual chan=%h casc=%b expected chan=%h casc=%b",
               tag, chanRev, cascRev, expChan(1'b1), model[W-1]);
    end
  endtask

  task automatic shiftOne(bit b);
    serialIn = b; shiftClkIn = 1'b1;
    ticks(4);
    shiftClkIn = 1'b0;
    ticks(4);
    for (int i = W - 1; i > 0; i--) model[i] = model[i-1];
    model[0] = b;
    history.push_back(b);
  endtask

  initial begin
    rst = 1'b1; shiftClkIn = 1'b0; serialIn = 1'b0; strobeN = 1'b1; enableIn = 1'b0;
    for (int i = 0; i < W; i++) model[i] = 1'b0;
    ticks(4);
    rst = 1'b0;
    ticks(4);
    compare("R1 reset cleared, R6 blank");

    // Load a pattern with display enabled; check after every shift
    enableIn = 1'b1;
    ticks(3);
    begin
      logic [31:0] pat = 32'hA5C3_0F96;
      for (int i = 0; i < W; i++) begin
        shiftOne(pat[i]);
        compare("R2 R7 R8 R9 shift");
      end
    end
    // R3: after W shifts the cascade shows the first bit in
    vectors++;
    if (cascFwd !== history[0]) begin
      misses++;
      $display("FAIL R3 after 32: actual %b expected %b", cascFwd, history[0]);
    end
    shiftOne(1'b1);
    vectors++;
    if (cascFwd !== history[1]) begin
      misses++;
      $display("FAIL R3 after 33: actual %b expected %b", cascFwd, history[1]);
    end

    // R2: a rising edge held steady does not shift
    serialIn = 1'b0; shiftClkIn = 1'b1;
    ticks(8);
    compare("R2 rising edge no shift");
    shiftClkIn = 1'b0;
    ticks(4);
    for (int i = W - 1; i > 0; i--) model[i] = model[i-1];
    model[0] = 1'b0;
    compare("R2 falling after hold");

    // R5: strobe low overrides both enable levels
    strobeN = 1'b0;
    ticks(3);
    compare("R5 strobe low enable high");
    enableIn = 1'b0;
    ticks(3);
    compare("R5 strobe low enable low");

    // R4: shift while both controls active, then reveal
    for (int i = 0; i < 5; i++) shiftOne(i[0]);
    compare("R4 R5 shift under strobe");
    strobeN = 1'b1;
    ticks(3);
    compare("R6 blank after strobe release");
    for (int i = 0; i < 3; i++) shiftOne(1'b1);
    compare("R4 R6 shift while blanked");
    enableIn = 1'b1;
    ticks(3);
    compare("R4 R7 reveal after blanking");

    // R10: control change visible after exactly two edges
    enableIn = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    vectors++;
    if (chanFwd !== '0) begin
      misses++;
      $display("FAIL R10 enable latency: actual %h expected %h", chanFwd, {W{1'b0}});
    end
    enableIn = 1'b1;
    ticks(3);

    // Mirror check with a single one in stage 1 (R8, R9)
    for (int i = 0; i < W; i++) shiftOne(i == W - 1);
    compare("R8 R9 single one");
    vectors++;
    if (chanFwd !== 32'h0000_0001 || chanRev !== 32'h8000_0000) begin
      misses++;
      $display("FAIL R8 R9 mirror: actual fwd=%h rev=%h expected fwd=%h rev=%h",
               chanFwd, chanRev, 32'h1, 32'h8000_0000);
    end

    // R1: reset in mid-run clears the chain
    rst = 1'b1;
    ticks(2);
    rst = 1'b0;
    for (int i = 0; i < W; i++) model[i] = 1'b0;
    ticks(4);
    compare("R1 reset mid-run");

    finishRun();
  end
endmodule